// File: doc/BRIEF.md
# Test-Pattern Receive Synchronizer with Bit and Error Counters

This block sits at the receive end of a link-test pattern path. It takes a serial bit stream, qualified by a clock enable, and checks it against the pattern the companion generator was set up to send. The pattern is either a feedback-shift-register sequence, given by a tap mask, or a fixed word repeated with a programmed period. The block uses the same mode, length and tap settings as the generator.

To find lock, the block first loads the incoming bits straight into its own shift register. It then predicts each next bit and needs a run of correct predictions before it reports in-sync. While in sync, the shift register runs on its own predictions. Each received bit is counted, and each bit that differs from the prediction is counted as an error. A load strobe from the host ends an integration window: it copies the running counts to the output registers and restarts the running counters, so the host can divide the two counts to get a bit error rate.

An all-zeros stream also passes the feedback test, and an all-ones stream can pass it as well. For this reason the block flags long runs of identical bits, so the host can qualify a lock before trusting it.

Top module: `bert_rx_sync`

## Requirements
- R1: After reset, inSync, allOnes, allZeros and cntOvf are low, and bitCount, errCount and rxWord are zero.
- R2: With cfgRepMode=0, the predicted bit is the XOR of the stored bits selected by cfgTaps, where tap bit k stands for the bit received k+1 positions earlier. Acquisition first loads cfgLen enabled bits, then needs 32 consecutive correct predictions, and inSync rises right after the last of them. An all-zeros stream also achieves lock.
- R3: With cfgRepMode=1, the predicted bit is the bit received cfgLen positions earlier, and a mispredicted bit restarts the run of 32. When lock is reached, rxWord captures the most recent 32 received bits, with bit 0 the newest.
- R4: While inSync is high, every enabled bit adds one to the running bit count, and every bit that differs from the prediction adds one to the running error count. The shift register advances on predicted bits, so one flipped bit costs exactly one error. Cycles with rxValid low change nothing.
- R5: On a rising edge of loadCnt, bitCount and errCount take the running counts and the running counters restart. At all other times bitCount and errCount hold their values.
- R6: With syncEn high, inSync drops on the bit that brings the error total over the last 64 in-sync bits to 6. Acquisition then restarts on its own.
- R7: With syncEn low, lock is never dropped for errors, and acquisition does not advance.
- R8: A rising edge of resync clears inSync on the next cycle and restarts acquisition.
- R9: allOnes or allZeros is high once the last 32 enabled bits were all ones or all zeros. It clears on the first enabled bit that differs.
- R10: The running counters saturate at their all-ones value, and cntOvf goes high and stays high until reset once either counter has saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | Clock enable for rxBit |
| rxBit | input | 1 | Received serial bit |
| cfgRepMode | input | 1 | 0 = feedback pattern, 1 = repeated word |
| cfgLen | input | LEN_W | Register length or repeat period, 1..MAX_LEN |
| cfgTaps | input | MAX_LEN | Feedback tap mask |
| syncEn | input | 1 | Enables acquisition progress and automatic loss of lock |
| resync | input | 1 | Rising edge forces reacquisition |
| loadCnt | input | 1 | Rising edge latches counts and restarts the window |
| inSync | output | 1 | Lock status |
| allOnes | output | 1 | Run of 32 or more ones received |
| allZeros | output | 1 | Run of 32 or more zeros received |
| rxWord | output | MAX_LEN | Received bits captured at lock |
| bitCount | output | BIT_W | Latched bit count |
| errCount | output | ERR_W | Latched error count |
| cntOvf | output | 1 | Sticky counter saturation flag |

## Verification
The bench drives a seven-stage feedback sequence with single flipped bits spaced far apart. This shows that one flip costs exactly one error, which separates a free-running predictor from one that follows the wire. Flips spaced ten bits apart expose the exact bit on which the loss-of-lock window trips. A five-bit repeated word with a flip during acquisition pins the restart of the correct-prediction run to a bit-exact lock point. Streams of all zeros and then all ones check the alias indicators at bit 31 versus bit 32, and long error and bit bursts under small counter widths reach saturation.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_SYNC   = 2'd2
  } syncState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftRaw;   // shift the received bit into the local register
    logic shiftPred;  // shift the predicted bit (free run while locked)
    logic capture;    // latch the received word at lock
    logic countBit;   // count this bit into the running counters
  } dpCtl_t;

endpackage

// File: rtl/bert_sat_cnt.sv
module bert_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         restart,
  output logic [W-1:0] value,
  output logic         atMax
);

  localparam logic [W-1:0] MAX_VAL = '1;

  assign atMax = (value == MAX_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (restart) begin
      value <= W'(inc);
    end else if (inc && !atMax) begin
      value <= value + W'(1);
    end
  end

endmodule

// File: rtl/bert_sync_ctrl.sv
module bert_sync_ctrl
  import bert_rx_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxValid,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             syncEn,
  input  logic             resync,
  input  logic             predErr,
  output dpCtl_t           ctl,
  output logic             inSync
);

  localparam int GOOD_W = $clog2(LOCK_RUN + 1);
  localparam int WCNT_W = $clog2(WIN_LEN + 1);

  syncState_t          state;
  logic                resyncQ;
  logic                resyncRise;
  logic [LEN_W-1:0]    fillCnt;
  logic [LEN_W:0]      fillNext;
  logic                fillDone;
  logic [GOOD_W-1:0]   goodCnt;
  logic                goodDone;
  logic [WIN_LEN-1:0]  errHist;
  logic [WCNT_W-1:0]   winCnt;
  logic [WCNT_W-1:0]   winNext;
  logic                overLimit;

  assign resyncRise = resync && !resyncQ;
  assign fillNext   = {1'b0, fillCnt} + (LEN_W + 1)'(1);
  assign fillDone   = fillNext >= {1'b0, cfgLen};
  assign goodDone   = goodCnt == GOOD_W'(LOCK_RUN - 1);
  assign winNext    = winCnt + WCNT_W'(predErr) - WCNT_W'(errHist[WIN_LEN-1]);
  assign overLimit  = winNext >= WCNT_W'(ERR_LIMIT);
  assign inSync     = (state == ST_SYNC);

  always_comb begin
    ctl           = '0;
    ctl.shiftRaw  = rxValid && (state != ST_SYNC);
    ctl.shiftPred = rxValid && (state == ST_SYNC);
    ctl.countBit  = rxValid && (state == ST_SYNC);
    ctl.capture   = rxValid && (state == ST_VERIFY) && syncEn && !predErr && goodDone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resyncQ <= 1'b0;
    end else begin
      resyncQ <= resync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_LOAD;
      fillCnt <= '0;
      goodCnt <= '0;
      errHist <= '0;
      winCnt  <= '0;
    end else if (resyncRise) begin
      state   <= ST_LOAD;
      fillCnt <= '0;
      goodCnt <= '0;
      errHist <= '0;
      winCnt  <= '0;
    end else if (rxValid) begin
      unique case (state)
        ST_LOAD: begin
          if (syncEn) begin
            if (fillDone) begin
              state   <= ST_VERIFY;
              fillCnt <= '0;
              goodCnt <= '0;
            end else begin
              fillCnt <= fillNext[LEN_W-1:0];
            end
          end
        end
        ST_VERIFY: begin
          if (syncEn) begin
            if (predErr) begin
              goodCnt <= '0;
            end else if (goodDone) begin
              state   <= ST_SYNC;
              errHist <= '0;
              winCnt  <= '0;
            end else begin
              goodCnt <= goodCnt + GOOD_W'(1);
            end
          end
        end
        ST_SYNC: begin
          if (syncEn && overLimit) begin
            state   <= ST_LOAD;
            fillCnt <= '0;
            goodCnt <= '0;
            errHist <= '0;
            winCnt  <= '0;
          end else begin
            errHist <= {errHist[WIN_LEN-2:0], predErr};
            winCnt  <= winNext;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/bert_sync_dp.sv
module bert_sync_dp
  import bert_rx_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6,
  parameter int BIT_W   = 32,
  parameter int ERR_W   = 24,
  parameter int RUN_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxValid,
  input  logic               rxBit,
  input  logic               cfgRepMode,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic [MAX_LEN-1:0] cfgTaps,
  input  logic               loadCnt,
  input  dpCtl_t             ctl,
  output logic               predErr,
  output logic [MAX_LEN-1:0] rxWord,
  output logic [BIT_W-1:0]   bitCount,
  output logic [ERR_W-1:0]   errCount,
  output logic               cntOvf,
  output logic               allOnes,
  output logic               allZeros
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [MAX_LEN-1:0] shreg;
  logic               repBit;
  logic               fbBit;
  logic               predBit;
  logic               loadQ;
  logic               loadRise;
  logic [BIT_W-1:0]   bitRun;
  logic [ERR_W-1:0]   errRun;
  logic               bitMax;
  logic               errMax;
  logic [RUN_W-1:0]   runCnt;
  logic               lastBit;

  // period tap for repeated-word mode
  always_comb begin
    repBit = 1'b0;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (cfgLen == LEN_W'(i + 1)) repBit = shreg[i];
    end
  end

  assign fbBit    = ^(shreg & cfgTaps);
  assign predBit  = cfgRepMode ? repBit : fbBit;
  assign predErr  = predBit ^ rxBit;
  assign loadRise = loadCnt && !loadQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      rxWord <= '0;
    end else begin
      if (ctl.shiftRaw) begin
        shreg <= {shreg[MAX_LEN-2:0], rxBit};
      end else if (ctl.shiftPred) begin
        shreg <= {shreg[MAX_LEN-2:0], predBit};
      end
      if (ctl.capture) begin
        rxWord <= {shreg[MAX_LEN-2:0], rxBit};
      end
    end
  end

  bert_sat_cnt #(.W(BIT_W)) i_bitRun (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (ctl.countBit),
    .restart(loadRise),
    .value  (bitRun),
    .atMax  (bitMax)
  );

  bert_sat_cnt #(.W(ERR_W)) i_errRun (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (ctl.countBit && predErr),
    .restart(loadRise),
    .value  (errRun),
    .atMax  (errMax)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadQ    <= 1'b0;
      bitCount <= '0;
      errCount <= '0;
      cntOvf   <= 1'b0;
    end else begin
      loadQ  <= loadCnt;
      cntOvf <= cntOvf || bitMax || errMax;
      if (loadRise) begin
        bitCount <= bitRun;
        errCount <= errRun;
      end
    end
  end

  // identical-bit run detector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCnt  <= '0;
      lastBit <= 1'b0;
    end else if (rxValid) begin
      lastBit <= rxBit;
      if (runCnt != '0 && rxBit == lastBit) begin
        if (runCnt != RUN_W'(RUN_LEN)) runCnt <= runCnt + RUN_W'(1);
      end else begin
        runCnt <= RUN_W'(1);
      end
    end
  end

  assign allOnes  = (runCnt == RUN_W'(RUN_LEN)) && lastBit;
  assign allZeros = (runCnt == RUN_W'(RUN_LEN)) && !lastBit;

endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync
  import bert_rx_pkg::*;
#(
  parameter int MAX_LEN   = 32,
  parameter int LEN_W     = $clog2(MAX_LEN + 1),
  parameter int BIT_W     = 32,
  parameter int ERR_W     = 24,
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 6,
  parameter int RUN_LEN   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxValid,
  input  logic               rxBit,
  input  logic               cfgRepMode,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic [MAX_LEN-1:0] cfgTaps,
  input  logic               syncEn,
  input  logic               resync,
  input  logic               loadCnt,
  output logic               inSync,
  output logic               allOnes,
  output logic               allZeros,
  output logic [MAX_LEN-1:0] rxWord,
  output logic [BIT_W-1:0]   bitCount,
  output logic [ERR_W-1:0]   errCount,
  output logic               cntOvf
);

  dpCtl_t ctl;
  logic   predErr;

  bert_sync_ctrl #(
    .LEN_W    (LEN_W),
    .LOCK_RUN (LOCK_RUN),
    .WIN_LEN  (WIN_LEN),
    .ERR_LIMIT(ERR_LIMIT)
  ) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxValid(rxValid),
    .cfgLen (cfgLen),
    .syncEn (syncEn),
    .resync (resync),
    .predErr(predErr),
    .ctl    (ctl),
    .inSync (inSync)
  );

  bert_sync_dp #(
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W),
    .BIT_W  (BIT_W),
    .ERR_W  (ERR_W),
    .RUN_LEN(RUN_LEN)
  ) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxValid   (rxValid),
    .rxBit     (rxBit),
    .cfgRepMode(cfgRepMode),
    .cfgLen    (cfgLen),
    .cfgTaps   (cfgTaps),
    .loadCnt   (loadCnt),
    .ctl       (ctl),
    .predErr   (predErr),
    .rxWord    (rxWord),
    .bitCount  (bitCount),
    .errCount  (errCount),
    .cntOvf    (cntOvf),
    .allOnes   (allOnes),
    .allZeros  (allZeros)
  );

endmodule

// File: rtl/bert_rx_sync_chk.sv
module bert_rx_sync_chk #(
  parameter int BIT_W = 32,
  parameter int ERR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rxValid,
  input logic             rxBit,
  input logic             syncEn,
  input logic             resync,
  input logic             loadCnt,
  input logic             inSync,
  input logic             allOnes,
  input logic             allZeros,
  input logic [BIT_W-1:0] bitCount,
  input logic [ERR_W-1:0] errCount,
  input logic             cntOvf
);

  p_lock_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inSync) |-> $past(syncEn));

  p_drop_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inSync) |-> $past(syncEn || resync));

  p_resync_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resync) |=> !inSync);

  p_run_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(allOnes && allZeros));

  p_ones_from_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(allOnes) |-> $past(rxValid && rxBit));

  p_hold_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(loadCnt) |=> ($stable(bitCount) && $stable(errCount)));

  p_err_le_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    BIT_W'(errCount) <= bitCount);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cntOvf |=> cntOvf);

endmodule

bind bert_rx_sync bert_rx_sync_chk #(
  .BIT_W(BIT_W),
  .ERR_W(ERR_W)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rxValid (rxValid),
  .rxBit   (rxBit),
  .syncEn  (syncEn),
  .resync  (resync),
  .loadCnt (loadCnt),
  .inSync  (inSync),
  .allOnes (allOnes),
  .allZeros(allZeros),
  .bitCount(bitCount),
  .errCount(errCount),
  .cntOvf  (cntOvf)
);

// File: tb/test_bert_rx_sync.sv
`timescale 1ns/1ps
module test_bert_rx_sync;

  localparam int MAX_LEN = 32;
  localparam int LEN_W   = 6;
  localparam int BIT_W   = 12;
  localparam int ERR_W   = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               rxValid = 1'b0;
  logic               rxBit = 1'b0;
  logic               cfgRepMode = 1'b0;
  logic [LEN_W-1:0]   cfgLen = 6'd7;
  logic [MAX_LEN-1:0] cfgTaps = 32'h60;
  logic               syncEn = 1'b1;
  logic               resync = 1'b0;
  logic               loadCnt = 1'b0;
  logic               inSync, allOnes, allZeros, cntOvf;
  logic [MAX_LEN-1:0] rxWord;
  logic [BIT_W-1:0]   bitCount;
  logic [ERR_W-1:0]   errCount;

  int errors = 0;
  int checks = 0;
  logic [6:0]  gen = 7'h5A;
  logic [31:0] hist = '0;
  int          repIdx = 0;
  localparam logic [4:0] REP_PAT = 5'b10110;

  always #4 clk = ~clk;

  bert_rx_sync #(.MAX_LEN(MAX_LEN), .BIT_W(BIT_W), .ERR_W(ERR_W)) i_bert_rx_sync (
    .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rxBit(rxBit),
    .cfgRepMode(cfgRepMode), .cfgLen(cfgLen), .cfgTaps(cfgTaps),
    .syncEn(syncEn), .resync(resync), .loadCnt(loadCnt),
    .inSync(inSync), .allOnes(allOnes), .allZeros(allZeros), .rxWord(rxWord),
    .bitCount(bitCount), .errCount(errCount), .cntOvf(cntOvf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    rxValid = 1'b1;
    rxBit   = b;
    hist    = {hist[30:0], b};
    @(posedge clk);
    #1;
    rxValid = 1'b0;
  endtask

  task automatic prbs(input int n, input int flipMod, input int flipAt);
    for (int i = 0; i < n; i++) begin
      logic nb;
      nb  = gen[6] ^ gen[5];
      gen = {gen[5:0], nb};
      sendBit(nb ^ ((flipMod > 0 && (i % flipMod) == flipAt) ? 1'b1 : 1'b0));
    end
  endtask

  task automatic repBits(input int n, input int flipIdx);
    for (int i = 0; i < n; i++) begin
      sendBit(REP_PAT[repIdx] ^ (i == flipIdx));
      repIdx = (repIdx + 1) % 5;
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(posedge clk);
    #1;
    sig = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 inSync", inSync, 0);
    chk("R1 allOnes", allOnes, 0);
    chk("R1 allZeros", allZeros, 0);
    chk("R1 cntOvf", cntOvf, 0);
    chk("R1 bitCount", bitCount, 0);
    chk("R1 errCount", errCount, 0);
    chk("R1 rxWord", rxWord, 0);

    // R2 feedback lock: 7 load + 32 good predictions
    prbs(38, 0, 0);
    chk("R2 no lock at bit 38", inSync, 0);
    prbs(1, 0, 0);
    chk("R2 lock at bit 39", inSync, 1);
    pulse(loadCnt);
    chk("R5 first window bits", bitCount, 0);
    chk("R10 no overflow yet", cntOvf, 0);

    // R4 single flips cost one error each
    prbs(200, 70, 50);
    pulse(loadCnt);
    chk("R4 bits counted", bitCount, 200);
    chk("R4 errors counted", errCount, 3);
    repeat (20) begin
      @(negedge clk);
      rxBit = ~rxBit;
    end
    pulse(loadCnt);
    chk("R5 restart and R4 idle bits ignored", bitCount, 0);
    chk("R5 restart errors", errCount, 0);

    // R6 loss of lock at sixth error within 64 bits
    prbs(100, 0, 0);
    prbs(50, 10, 0);
    chk("R6 five errors keep lock", inSync, 1);
    prbs(1, 1, 0);
    chk("R6 sixth error drops lock", inSync, 0);
    prbs(38, 0, 0);
    chk("R6 reacquire not yet", inSync, 0);
    prbs(1, 0, 0);
    chk("R6 reacquired", inSync, 1);

    // R8 resync
    pulse(resync);
    chk("R8 resync clears lock", inSync, 0);
    prbs(38, 0, 0);
    chk("R8 relock not yet", inSync, 0);
    prbs(1, 0, 0);
    chk("R8 relocked", inSync, 1);

    // R7 / R10 errors with syncEn low, error counter saturates
    syncEn = 1'b0;
    pulse(loadCnt);
    prbs(20, 1, 0);
    prbs(10, 0, 0);
    chk("R7 lock kept with syncEn low", inSync, 1);
    pulse(loadCnt);
    chk("R10 error count saturates", errCount, 15);
    chk("R10 bits in window", bitCount, 30);
    chk("R10 overflow flag", cntOvf, 1);

    // R7 acquisition frozen
    pulse(resync);
    prbs(100, 0, 0);
    chk("R7 no acquisition while disabled", inSync, 0);
    syncEn = 1'b1;
    prbs(38, 0, 0);
    chk("R7 enable then not yet", inSync, 0);
    prbs(1, 0, 0);
    chk("R7 enable then lock", inSync, 1);

    // R10 bit counter saturation
    pulse(loadCnt);
    prbs(4200, 0, 0);
    pulse(loadCnt);
    chk("R10 bit count saturates", bitCount, 4095);
    chk("R10 no errors", errCount, 0);
    chk("R10 overflow sticky", cntOvf, 1);

    // R3 repeated word, flip at bit 26 restarts the run -> lock at 63
    cfgRepMode = 1'b1;
    cfgLen     = 6'd5;
    pulse(resync);
    repBits(62, 25);
    chk("R3 restart delays lock", inSync, 0);
    repBits(1, -1);
    chk("R3 lock at bit 63", inSync, 1);
    chk("R3 captured word", rxWord, hist);
    pulse(loadCnt);
    repBits(50, 10);
    repBits(0, -1);
    pulse(loadCnt);
    chk("R3 bits counted", bitCount, 50);
    chk("R3 errors counted", errCount, 1);

    // R9 run indicators and zeros alias
    cfgRepMode = 1'b0;
    cfgLen     = 6'd7;
    pulse(resync);
    sendBit(1'b1);
    for (int i = 0; i < 31; i++) sendBit(1'b0);
    chk("R9 31 zeros", allZeros, 0);
    sendBit(1'b0);
    chk("R9 32 zeros", allZeros, 1);
    chk("R9 ones low", allOnes, 0);
    for (int i = 0; i < 60; i++) sendBit(1'b0);
    chk("R2 zeros alias locks", inSync, 1);
    sendBit(1'b1);
    chk("R9 zeros cleared", allZeros, 0);
    for (int i = 0; i < 30; i++) sendBit(1'b1);
    chk("R9 31 ones", allOnes, 0);
    sendBit(1'b1);
    chk("R9 32 ones", allOnes, 1);
    sendBit(1'b0);
    chk("R9 ones cleared", allOnes, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule